// File: doc/BRIEF.md
# Iterative Radix-2 Decimation-in-Frequency FFT Core

This core takes a frame of N complex fixed-point samples and produces its N-point discrete Fourier transform. N is a power of two from 4 to 256, and the default is 8. Samples enter through a valid/ready stream and are stored in an in-place frame memory. Once the frame is full, the core runs log2 N stages of N/2 butterflies each, at one butterfly per clock.

The butterfly is the decimation-in-frequency kind. The sum of the two operands goes to the upper slot. The difference goes to the lower slot after it is rotated by the stage twiddle. The finished spectrum therefore sits in memory in bit-reversed order. Readout addresses the memory through a bit-reversed counter, so bins leave in natural order with a flag on the final bin.

A parameter turns the core into an inverse transform. In that mode the twiddles are conjugated, and the same 1/N scale applies. The twiddle table is computed during elaboration. Every butterfly halves its outputs, which gives a total scale of 1/N and keeps the data inside 16 bits.

Top module: `fft_dif`

## Requirements
- R1: In the load phase `in_ready` is 1, and each cycle with `in_valid` high stores the next sample, in arrival order. After the N-th sample `in_ready` stays 0 through computation and readout, and samples offered in that time are ignored.
- R2: `done` is a single-cycle pulse. Counting the clock edge that accepts the last sample as edge 0, `done` is first high after edge N·log2(N)/2.
- R3: Each butterfly forms its upper output as floor((a+b)/2). Its lower output is round-half-up of (a−b)·W/2, using a Q1.14 twiddle W = cos θ − j·sin θ with θ = 2π·e/N. In stage s (s = 0 first), butterfly offset k within a group of span N/2^(s+1) uses e = k·2^s.
- R4: In forward mode, bin k equals (1/N)·Σ x[n]·e^(−j2πkn/N) to within 4 LSB per component.
- R5: Readout asserts `out_valid` for exactly N consecutive cycles, starting in the `done` cycle. Bin k is presented in the k-th of these cycles (bins in natural order), and `out_last` is 1 only on bin N−1.
- R6: With INVERSE=1, each twiddle is conjugated (W = cos θ + j·sin θ). Output n then equals (1/N)·Σ X[k]·e^(+j2πkn/N) to within 4 LSB per component.
- R7: A rotated difference outside the signed 16-bit range saturates to 32767 or −32768.
- R8: The cycle after `out_last`, the core is back in the load phase with `in_ready` 1 and `out_valid` 0, and it accepts a new frame.
- R9: While `rst_n` is 0, `in_ready` is 1 and `out_valid`, `out_last` and `done` are 0. A partly loaded frame is dropped, and the next sample after reset becomes sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Core accepts samples (load phase) |
| in_re | input | DW | Input sample, real part, signed |
| in_im | input | DW | Input sample, imaginary part, signed |
| out_valid | output | 1 | Output bin present |
| out_last | output | 1 | Output bin is bin N−1 |
| out_re | output | DW | Output bin, real part, signed |
| out_im | output | DW | Output bin, imaginary part, signed |
| done | output | 1 | One-cycle pulse when the final stage has completed |

## Verification
The hardest state to reach from the ports is saturation in the lower butterfly branch. It only happens when a full-scale positive sample and a full-scale negative sample sit N/2 apart and meet a 45-degree twiddle. The bench builds exactly that frame, with an exact hand-derived expected spectrum, so the clamp, the floor halving and the half-up rounding all show up as single-LSB differences. The bench also keeps `in_valid` high with junk data for the whole busy period, to show that no junk sample reaches the results. It also resets the core in the middle of a load.

// File: rtl/fft_dif_pkg.sv
package fft_dif_pkg;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_CALC  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

  localparam real PI_R = 3.14159265358979323846;

  // Round a real value to the nearest integer, halves away from zero.
  function automatic int round_real(real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
  parameter int N       = 8,
  parameter int TWW     = 16,
  parameter bit INVERSE = 1'b0,
  localparam int P      = $clog2(N)
) (
  input  logic [P-2:0]           idx,
  output logic signed [TWW-1:0]  w_re,
  output logic signed [TWW-1:0]  w_im
);
  import fft_dif_pkg::*;

  localparam real ONE = real'(2 ** (TWW - 2));

  logic signed [TWW-1:0] tab_re [N/2];
  logic signed [TWW-1:0] tab_im [N/2];

  for (genvar e = 0; e < N/2; e++) begin : g_ent
    localparam real ANG = 2.0 * PI_R * real'(e) / real'(N);
    localparam int  CRE = round_real(ONE * $cos(ANG));
    localparam int  SIM = round_real(ONE * $sin(ANG));
    localparam int  CIM = INVERSE ? SIM : -SIM;
    assign tab_re[e] = TWW'(CRE);
    assign tab_im[e] = TWW'(CIM);
  end

  assign w_re = tab_re[idx];
  assign w_im = tab_im[idx];

endmodule

// File: rtl/fft_bfly.sv
module fft_bfly #(
  parameter int DW  = 16,
  parameter int TWW = 16
) (
  input  logic signed [DW-1:0]  a_re,
  input  logic signed [DW-1:0]  a_im,
  input  logic signed [DW-1:0]  b_re,
  input  logic signed [DW-1:0]  b_im,
  input  logic signed [TWW-1:0] w_re,
  input  logic signed [TWW-1:0] w_im,
  output logic signed [DW-1:0]  u_re,
  output logic signed [DW-1:0]  u_im,
  output logic signed [DW-1:0]  l_re,
  output logic signed [DW-1:0]  l_im
);
  localparam int FRAC = TWW - 2;
  localparam int SW   = DW + 1;
  localparam int PW   = SW + TWW + 1;
  localparam logic signed [PW-1:0] Q_MAX = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] Q_MIN = -Q_MAX - PW'(1);
  localparam logic signed [PW-1:0] HALF  = PW'(2 ** FRAC);

  logic signed [SW-1:0] s_re, s_im, d_re, d_im;
  logic signed [PW-1:0] dx_re, dx_im, wx_re, wx_im;
  logic signed [PW-1:0] p_re, p_im, q_re, q_im;

  // sum / difference in one extra bit
  assign s_re = SW'(a_re) + SW'(b_re);
  assign s_im = SW'(a_im) + SW'(b_im);
  assign d_re = SW'(a_re) - SW'(b_re);
  assign d_im = SW'(a_im) - SW'(b_im);

  // upper branch: halve by dropping the LSB (floor)
  assign u_re = s_re[SW-1:1];
  assign u_im = s_im[SW-1:1];

  // lower branch: rotate, then scale by 2^-(FRAC+1) with half-up rounding
  assign dx_re = PW'(d_re);
  assign dx_im = PW'(d_im);
  assign wx_re = PW'(w_re);
  assign wx_im = PW'(w_im);
  assign p_re  = dx_re * wx_re - dx_im * wx_im;
  assign p_im  = dx_re * wx_im + dx_im * wx_re;
  assign q_re  = (p_re + HALF) >>> (FRAC + 1);
  assign q_im  = (p_im + HALF) >>> (FRAC + 1);

  always_comb begin
    if (q_re > Q_MAX)      l_re = Q_MAX[DW-1:0];
    else if (q_re < Q_MIN) l_re = Q_MIN[DW-1:0];
    else                   l_re = q_re[DW-1:0];
    if (q_im > Q_MAX)      l_im = Q_MAX[DW-1:0];
    else if (q_im < Q_MIN) l_im = Q_MIN[DW-1:0];
    else                   l_im = q_im[DW-1:0];
  end

endmodule

// File: rtl/fft_seq.sv
module fft_seq #(
  parameter int N  = 8,
  localparam int P = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         load_en,
  output logic         bf_en,
  output logic [P-1:0] cnt,
  output logic [P-1:0] addr_a,
  output logic [P-1:0] addr_b,
  output logic [P-2:0] tw_idx,
  output logic         out_valid,
  output logic         out_last,
  output logic         done
);
  import fft_dif_pkg::*;

  localparam int SW = $clog2(P + 1);
  localparam logic [P-1:0]  CNT_LAST  = P'(N - 1);
  localparam logic [P-1:0]  HALF_LAST = P'(N / 2 - 1);
  localparam logic [SW-1:0] STG_LAST  = SW'(P - 1);

  phase_e        phase_q, phase_d;
  logic [P-1:0]  cnt_q, cnt_d;
  logic [SW-1:0] stg_q, stg_d;
  logic          done_q, done_d;
  logic          adv;

  // next-state
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    stg_d   = stg_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_LOAD: begin
        cnt_d = cnt_q + P'(1);
        if (cnt_q == CNT_LAST) begin
          phase_d = PH_CALC;       // frame full: start computing
          cnt_d   = '0;
          stg_d   = '0;
        end
      end
      PH_CALC: begin
        cnt_d = cnt_q + P'(1);
        if (cnt_q == HALF_LAST) begin
          cnt_d = '0;
          if (stg_q == STG_LAST) begin
            phase_d = PH_DRAIN;
            done_d  = 1'b1;
          end else begin
            stg_d = stg_q + SW'(1);
          end
        end
      end
      PH_DRAIN: begin
        cnt_d = cnt_q + P'(1);
        if (cnt_q == CNT_LAST) begin
          phase_d = PH_LOAD;
          cnt_d   = '0;
        end
      end
      default: begin
        phase_d = PH_LOAD;
        cnt_d   = '0;
      end
    endcase
  end

  assign adv = (phase_q != PH_LOAD) || in_valid;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      stg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (adv) begin
        phase_q <= phase_d;
        cnt_q   <= cnt_d;
        stg_q   <= stg_d;
      end
    end
  end

  // butterfly addressing: span h = N >> (stage+1)
  logic [P-1:0] span, mask, koff, kshift;
  always_comb begin
    span   = P'(1) << (P - 1 - int'(stg_q));
    mask   = span - P'(1);
    koff   = cnt_q & mask;
    addr_a = ((cnt_q & ~mask) << 1) | koff;
    addr_b = addr_a | span;
    kshift = koff << stg_q;
  end
  assign tw_idx = kshift[P-2:0];

  assign in_ready  = (phase_q == PH_LOAD);
  assign load_en   = in_ready && in_valid;
  assign bf_en     = (phase_q == PH_CALC);
  assign out_valid = (phase_q == PH_DRAIN);
  assign out_last  = out_valid && (cnt_q == CNT_LAST);
  assign done      = done_q;
  assign cnt       = cnt_q;

endmodule

// File: rtl/fft_dif.sv
module fft_dif #(
  parameter int N       = 8,
  parameter int DW      = 16,
  parameter int TWW     = 16,
  parameter bit INVERSE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 done
);
  localparam int P = $clog2(N);

  logic          load_en, bf_en;
  logic [P-1:0]  cnt, addr_a, addr_b, rev_addr;
  logic [P-2:0]  tw_idx;
  logic signed [TWW-1:0] w_re, w_im;
  logic signed [DW-1:0]  u_re, u_im, l_re, l_im;

  logic signed [DW-1:0] mem_re [N];
  logic signed [DW-1:0] mem_im [N];

  fft_seq #(.N(N)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .load_en  (load_en),
    .bf_en    (bf_en),
    .cnt      (cnt),
    .addr_a   (addr_a),
    .addr_b   (addr_b),
    .tw_idx   (tw_idx),
    .out_valid(out_valid),
    .out_last (out_last),
    .done     (done)
  );

  fft_twiddle_rom #(.N(N), .TWW(TWW), .INVERSE(INVERSE)) u_rom (
    .idx  (tw_idx),
    .w_re (w_re),
    .w_im (w_im)
  );

  fft_bfly #(.DW(DW), .TWW(TWW)) u_bfly (
    .a_re (mem_re[addr_a]),
    .a_im (mem_im[addr_a]),
    .b_re (mem_re[addr_b]),
    .b_im (mem_im[addr_b]),
    .w_re (w_re),
    .w_im (w_im),
    .u_re (u_re),
    .u_im (u_im),
    .l_re (l_re),
    .l_im (l_im)
  );

  // in-place frame memory (datapath storage, no reset)
  always_ff @(posedge clk) begin
    if (load_en) begin
      mem_re[cnt] <= in_re;
      mem_im[cnt] <= in_im;
    end else if (bf_en) begin
      mem_re[addr_a] <= u_re;
      mem_im[addr_a] <= u_im;
      mem_re[addr_b] <= l_re;
      mem_im[addr_b] <= l_im;
    end
  end

  // natural-order readout through bit-reversed addressing
  always_comb begin
    for (int i = 0; i < P; i++) rev_addr[i] = cnt[P-1-i];
  end

  assign out_re = mem_re[rev_addr];
  assign out_im = mem_im[rev_addr];

endmodule

// File: rtl/fft_dif_chk.sv
module fft_dif_chk #(
  parameter int N = 8
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_last,
  input logic done
);
  localparam int CW = $clog2(N) + 1;
  logic [CW-1:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vcnt <= '0;
    else if (out_last)  vcnt <= '0;
    else if (out_valid) vcnt <= vcnt + CW'(1);
  end

  // R2: done lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: readout opens exactly with done
  a_r5_readout_starts_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  a_r5_done_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  // R5: last flag exactly on the N-th readout cycle
  a_r5_last_position: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && vcnt == CW'(N - 1)));

  a_r5_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && vcnt != CW'(N - 1)) |=> out_valid);

  // R1: no input accepted while bins are leaving
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8: back to loading right after the final bin
  a_r8_back_to_load: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (in_ready && !out_valid));

endmodule

bind fft_dif fft_dif_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_last (out_last),
  .done     (done)
);

// File: tb/test_fft_dif.sv
`timescale 1ns/1ps
module test_fft_dif;
  localparam int N   = 8;
  localparam int P   = 3;
  localparam int TOL = 4;
  localparam real PI = 3.14159265358979323846;

  logic clk, rst_n, in_valid;
  logic signed [15:0] in_re, in_im;
  logic f_ready, f_valid, f_last, f_done;
  logic i_ready, i_valid, i_last, i_done;
  logic signed [15:0] f_re, f_im, v_re, v_im;

  fft_dif #(.N(N), .INVERSE(1'b0)) i_fft_dif (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(f_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(f_valid), .out_last(f_last),
    .out_re(f_re), .out_im(f_im), .done(f_done));

  fft_dif #(.N(N), .INVERSE(1'b1)) i_fft_dif_inv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(i_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(i_valid), .out_last(i_last),
    .out_re(v_re), .out_im(v_im), .done(i_done));

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int errors = 0;
  int st_re[N], st_im[N];
  int gf_re[N], gf_im[N], gi_re[N], gi_im[N];
  real ex_re[N], ex_im[N];
  int lat;

  // stimulus table: kind, amplitude, parameter, gaps between samples
  // kind 0 = constant, 1 = complex tone at bin PB, 2 = impulse at PB,
  // 3 = ramps, 4 = alternating sign
  localparam int NV = 7;
  localparam int PK[NV] = '{0, 1, 1, 2, 3, 4, 1};
  localparam int PA[NV] = '{1000, 4000, 6000, 8000, 7000, 5000, 3000};
  localparam int PB[NV] = '{0, 1, 3, 5, 0, 0, 7};
  localparam int PG[NV] = '{0, 0, 1, 0, 1, 0, 0};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic make_frame(input int kind, input int amp, input int prm);
    for (int n = 0; n < N; n++) begin
      real th;
      th = 2.0 * PI * real'(prm * n) / real'(N);
      case (kind)
        0: begin st_re[n] = amp; st_im[n] = 0; end
        1: begin st_re[n] = $rtoi(real'(amp) * $cos(th));
                 st_im[n] = $rtoi(real'(amp) * $sin(th)); end
        2: begin st_re[n] = (n == prm) ? amp : 0;
                 st_im[n] = (n == prm) ? -amp / 2 : 0; end
        3: begin st_re[n] = amp * (n - N / 2) / N;
                 st_im[n] = amp * (((3 * n) % N) - 4) / N; end
        default: begin st_re[n] = (n % 2 == 1) ? -amp : amp;
                       st_im[n] = amp / 3; end
      endcase
    end
  endtask

  task automatic ref_dft(input bit inv);
    for (int k = 0; k < N; k++) begin
      ex_re[k] = 0.0;
      ex_im[k] = 0.0;
      for (int n = 0; n < N; n++) begin
        real th;
        th = (inv ? 2.0 : -2.0) * PI * real'(k * n) / real'(N);
        ex_re[k] += real'(st_re[n]) * $cos(th) - real'(st_im[n]) * $sin(th);
        ex_im[k] += real'(st_re[n]) * $sin(th) + real'(st_im[n]) * $cos(th);
      end
      ex_re[k] = ex_re[k] / real'(N);
      ex_im[k] = ex_im[k] / real'(N);
    end
  endtask

  function automatic bit near(input int got, input real exp);
    real d;
    d = real'(got) - exp;
    return (d <= real'(TOL)) && (d >= -real'(TOL));
  endfunction

  // load a frame, keep junk on the input while busy, collect both outputs
  task automatic run_frame(input bit gaps);
    for (int i = 0; i < N; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); in_valid = 1'b0; in_re = 16'sd999; in_im = 16'sd999;
      end
      @(negedge clk);
      in_valid = 1'b1; in_re = 16'(st_re[i]); in_im = 16'(st_im[i]);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b1; in_re = 16'sh5a5a; in_im = -16'sd1234;   // R1 junk
    lat = 1;
    chk(!f_ready, "R1", "in_ready low after frame", int'(f_ready), 0);
    while (!f_done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    for (int i = 0; i < N; i++) begin
      if (i > 0) @(negedge clk);
      chk(f_valid && i_valid, "R5", $sformatf("out_valid bin %0d", i),
          int'(f_valid), 1);
      chk(f_last == (i == N - 1), "R5", $sformatf("out_last bin %0d", i),
          int'(f_last), int'(i == N - 1));
      gf_re[i] = f_re; gf_im[i] = f_im;
      gi_re[i] = v_re; gi_im[i] = v_im;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(f_ready && !f_valid, "R8", "back to load after last",
        int'(f_ready), 1);
  endtask

  task automatic cmp_float(input string tag);
    ref_dft(1'b0);
    for (int k = 0; k < N; k++) begin
      chk(near(gf_re[k], ex_re[k]) && near(gf_im[k], ex_im[k]), "R4",
          $sformatf("%s fwd bin %0d re/im %0d/%0d", tag, k, gf_re[k], gf_im[k]),
          gf_re[k], $rtoi(ex_re[k]));
    end
    ref_dft(1'b1);
    for (int k = 0; k < N; k++) begin
      chk(near(gi_re[k], ex_re[k]) && near(gi_im[k], ex_im[k]), "R6",
          $sformatf("%s inv out %0d re/im %0d/%0d", tag, k, gi_re[k], gi_im[k]),
          gi_re[k], $rtoi(ex_re[k]));
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sat_re[N];
    int sat_im[N];
    sat_re = '{-1, 8191, 0, 0, 1, -8191, 0, 0};
    sat_im = '{-1, 0, 0, -8192, 1, 0, 0, 8192};
    rst_n = 1'b0; in_valid = 1'b0; in_re = '0; in_im = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(f_ready && !f_valid && !f_last && !f_done, "R9", "reset outputs",
        int'({f_ready, f_valid, f_last, f_done}), 8);
    rst_n = 1'b1;

    // table-driven frames
    for (int v = 0; v < NV; v++) begin
      make_frame(PK[v], PA[v], PB[v]);
      run_frame(PG[v] != 0);
      chk(lat == N * P / 2 + 1, "R2", $sformatf("done latency row %0d", v),
          lat, N * P / 2 + 1);
      cmp_float($sformatf("row%0d", v));
    end

    // R3/R4: constant input gives exact single DC bin
    make_frame(0, 1000, 0);
    run_frame(1'b0);
    for (int k = 0; k < N; k++)
      chk(gf_re[k] == ((k == 0) ? 1000 : 0) && gf_im[k] == 0, "R3",
          $sformatf("DC exact bin %0d", k), gf_re[k], (k == 0) ? 1000 : 0);

    // R7/R3: full-scale pair meeting the 45 degree twiddle saturates
    for (int n = 0; n < N; n++) begin st_re[n] = 0; st_im[n] = 0; end
    st_re[1] = 32767;  st_im[1] = 32767;
    st_re[5] = -32768; st_im[5] = -32768;
    run_frame(1'b0);
    for (int k = 0; k < N; k++) begin
      chk(gf_re[k] == sat_re[k], "R7", $sformatf("sat frame bin %0d re", k),
          gf_re[k], sat_re[k]);
      chk(gf_im[k] == sat_im[k], "R3", $sformatf("sat frame bin %0d im", k),
          gf_im[k], sat_im[k]);
    end

    // R9: reset in the middle of a load drops the partial frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; in_re = 16'sd7777; in_im = -16'sd7777;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(f_ready && !f_valid && !f_done, "R9", "async reset mid-load",
        int'(f_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    make_frame(1, 5000, 2);
    run_frame(1'b0);
    chk(lat == N * P / 2 + 1, "R9", "latency after reset", lat, N * P / 2 + 1);
    cmp_float("after_reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule